// File: doc/BRIEF.md
# Watermark FIFO Mailbox Channel

A one-way word channel between a sending side and a receiving side that share one register bus. The sender writes words into a first-in first-out store by writing a push register, and the receiver takes them out, oldest first, by reading a pop register. Each bus access is one cycle wide. A write drives `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` for one cycle. A read drives `bus_req` and `bus_addr` with `bus_we` low, and `bus_rdata` holds the result during that same cycle.

A programmable watermark is compared with the number of stored words. A status register shows the live full, empty and watermark levels next to two sticky error flags. Writing a reset register empties the store, clears the sticky flags and restores the watermark. Changes in level and errored accesses record events in a shared interrupt status register that is cleared by writing ones. Each side has its own enable mask, and that mask gates the side's own interrupt line.

Register byte offsets:

| Offset | Register |
|--------|----------|
| 0xAC | push (write) |
| 0xB0 | pop (read) |
| 0xB4 | level status |
| 0xB8 | watermark |
| 0xBC | sender enable mask |
| 0xC0 | receiver enable mask |
| 0xC4 | interrupt clear |
| 0xC8 | interrupt status |
| 0xCC | store reset |

Top module: `mbox_fifo_chan`

## Requirements
- R1: A write to 0xAC stores a word while fewer than DEPTH words are held. A read of 0xB0 returns the oldest stored word and removes it, so words leave in the order they were written.
- R2: Reading 0xB4 returns the live levels and the sticky flags in these bits:
  - bit 0 is 1 when the word count is greater than or equal to the watermark.
  - bit 1 is 1 when the count equals DEPTH.
  - bit 2 is 1 when the count is 0.
  - bits 3 and 4 are the sticky flags described in R4 and R3.
  - all other bits read 0.
- R3: A push while DEPTH words are held is discarded, so the stored words and the count are unchanged. It sets sticky status bit 4 and interrupt status bit 6.
- R4: A pop while the store is empty returns 0 and leaves the count unchanged. It sets sticky status bit 3 and interrupt status bit 7.
- R5: Status bits 3 and 4 stay set until a write to 0xCC with bit 0 set. That write also empties the store and sets the watermark to DEPTH. A write to 0xCC with bit 0 clear has no effect.
- R6: The watermark at 0xB8 reads DEPTH after reset. When the watermark level of R2 goes from 0 to 1, interrupt status bit 4 is set. When it goes from 1 to 0, interrupt status bit 5 is set.
- R7: Interrupt status bit 2 is set when the store becomes full. Bit 3 is set when it becomes empty. Bit 8 is set when it stops being empty.
- R8: Writing 0xC4 clears each interrupt status bit whose data bit is 1 and leaves bits written 0 unchanged. Interrupt status at 0xC8 is 0 after reset, and its bits 0, 1 and 9 and above always read 0.
- R9: `irq_tx` is high when any interrupt status bit is set whose bit in the mask at 0xBC is also set. `irq_rx` works the same way with the mask at 0xC0. Both masks read back with only bits 2 to 8 kept, and both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of the read |
| irq_tx | output | 1 | Sender-side interrupt |
| irq_rx | output | 1 | Receiver-side interrupt |

## Verification
The bench builds the block with DEPTH set to 8 and the default 32-bit data and 8-bit address. This keeps a random mix of pushes and pops regularly at both ends of the store, so full, empty, overflow and underflow all occur many times. With an 8-word store, random watermark values from 0 to 15 cover three cases: a flag that is always set, thresholds crossed in both directions, and values above the depth that can never be reached.

// File: rtl/mbox_fifo_pkg.sv
package mbox_fifo_pkg;

  // Register byte offsets (decoded by software, so kept fixed)
  localparam logic [7:0] OFS_PUSH  = 8'hAC;
  localparam logic [7:0] OFS_POP   = 8'hB0;
  localparam logic [7:0] OFS_STAT  = 8'hB4;
  localparam logic [7:0] OFS_WMARK = 8'hB8;
  localparam logic [7:0] OFS_EN_TX = 8'hBC;
  localparam logic [7:0] OFS_EN_RX = 8'hC0;
  localparam logic [7:0] OFS_CLR   = 8'hC4;
  localparam logic [7:0] OFS_ISTAT = 8'hC8;
  localparam logic [7:0] OFS_RST   = 8'hCC;

  // Interrupt status bit positions
  localparam int IB_FULL   = 2;
  localparam int IB_EMPTY  = 3;
  localparam int IB_WM_UP  = 4;
  localparam int IB_WM_DN  = 5;
  localparam int IB_OVF    = 6;
  localparam int IB_UDF    = 7;
  localparam int IB_NEMPTY = 8;
  localparam int IRQ_W     = 9;
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 9'h1FC;

  typedef struct packed {
    logic wm;
    logic full;
    logic empty;
  } lvl_t;

endpackage

// File: rtl/mbox_fifo_store.sv
module mbox_fifo_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty,
  output logic          ovf_ev,
  output logic          udf_ev,
  output logic          ovf_stk,
  output logic          udf_stk
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign ovf_ev  = push & full;
  assign udf_ev  = pop & empty;
  assign rdata   = empty ? '0 : mem[rp_q];
  assign fill    = cnt_q;
  assign ovf_stk = ovf_q;
  assign udf_stk = udf_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q | ovf_ev;
    udf_d = udf_q | udf_ev;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
      udf_d = 1'b0;
    end else begin
      if (do_push) wp_d = wrap_inc(wp_q);
      if (do_pop)  rp_d = wrap_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  // Storage array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (do_push & ~flush) mem[wp_q] <= wdata;
  end

endmodule

// File: rtl/mbox_irq_ctl.sv
module mbox_irq_ctl
  import mbox_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lvl_t             lvl,
  input  logic             ovf_ev,
  input  logic             udf_ev,
  input  logic             clr_we,
  input  logic             en_tx_we,
  input  logic             en_rx_we,
  input  logic [IRQ_W-1:0] wbits,
  output logic [IRQ_W-1:0] istat,
  output logic [IRQ_W-1:0] en_tx,
  output logic [IRQ_W-1:0] en_rx,
  output logic             irq_tx,
  output logic             irq_rx
);

  lvl_t             prev_q;
  logic [IRQ_W-1:0] ev, ist_q, ist_d, etx_q, etx_d, erx_q, erx_d;

  always_comb begin
    ev            = '0;
    ev[IB_FULL]   = lvl.full  & ~prev_q.full;
    ev[IB_EMPTY]  = lvl.empty & ~prev_q.empty;
    ev[IB_NEMPTY] = ~lvl.empty & prev_q.empty;
    ev[IB_WM_UP]  = lvl.wm  & ~prev_q.wm;
    ev[IB_WM_DN]  = ~lvl.wm & prev_q.wm;
    ev[IB_OVF]    = ovf_ev;
    ev[IB_UDF]    = udf_ev;
  end

  always_comb begin
    ist_d = clr_we ? (ist_q & ~wbits) : ist_q;
    ist_d = (ist_d | ev) & IRQ_IMPL;
    etx_d = en_tx_we ? (wbits & IRQ_IMPL) : etx_q;
    erx_d = en_rx_we ? (wbits & IRQ_IMPL) : erx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '{wm: 1'b0, full: 1'b0, empty: 1'b1};
      ist_q  <= '0;
      etx_q  <= '0;
      erx_q  <= '0;
    end else begin
      prev_q <= lvl;
      ist_q  <= ist_d;
      etx_q  <= etx_d;
      erx_q  <= erx_d;
    end
  end

  assign istat  = ist_q;
  assign en_tx  = etx_q;
  assign en_rx  = erx_q;
  assign irq_tx = |(ist_q & etx_q);
  assign irq_rx = |(ist_q & erx_q);

endmodule

// File: rtl/mbox_fifo_chan.sv
module mbox_fifo_chan
  import mbox_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_tx,
  output logic          irq_rx
);

  localparam int CW = $clog2(DEPTH + 1);

  logic             wr, rd;
  logic             push_req, pop_req, flush_req, wm_we, clr_we, etx_we, erx_we;
  logic [CW-1:0]    fill, wm_q, wm_d;
  logic             full, empty, ovf_ev, udf_ev, ovf_stk, udf_stk;
  logic [DW-1:0]    pop_data;
  logic [IRQ_W-1:0] istat, en_tx, en_rx;
  lvl_t             lvl;
  logic             unused_wdata;

  assign wr        = bus_req & bus_we;
  assign rd        = bus_req & ~bus_we;
  assign push_req  = wr & (bus_addr == AW'(OFS_PUSH));
  assign pop_req   = rd & (bus_addr == AW'(OFS_POP));
  assign flush_req = wr & (bus_addr == AW'(OFS_RST)) & bus_wdata[0];
  assign wm_we     = wr & (bus_addr == AW'(OFS_WMARK));
  assign clr_we    = wr & (bus_addr == AW'(OFS_CLR));
  assign etx_we    = wr & (bus_addr == AW'(OFS_EN_TX));
  assign erx_we    = wr & (bus_addr == AW'(OFS_EN_RX));
  assign unused_wdata = ^bus_wdata[DW-1:IRQ_W];

  mbox_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_req),
    .push    (push_req),
    .pop     (pop_req),
    .wdata   (bus_wdata),
    .rdata   (pop_data),
    .fill    (fill),
    .full    (full),
    .empty   (empty),
    .ovf_ev  (ovf_ev),
    .udf_ev  (udf_ev),
    .ovf_stk (ovf_stk),
    .udf_stk (udf_stk)
  );

  // Watermark register
  always_comb begin
    wm_d = wm_q;
    if (flush_req)  wm_d = CW'(DEPTH);
    else if (wm_we) wm_d = bus_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wm_q <= CW'(DEPTH);
    else        wm_q <= wm_d;
  end

  assign lvl = '{wm: (fill >= wm_q), full: full, empty: empty};

  mbox_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl),
    .ovf_ev   (ovf_ev),
    .udf_ev   (udf_ev),
    .clr_we   (clr_we),
    .en_tx_we (etx_we),
    .en_rx_we (erx_we),
    .wbits    (bus_wdata[IRQ_W-1:0]),
    .istat    (istat),
    .en_tx    (en_tx),
    .en_rx    (en_rx),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        AW'(OFS_POP):   bus_rdata = pop_data;
        AW'(OFS_STAT):  bus_rdata = {{(DW-5){1'b0}}, ovf_stk, udf_stk, lvl.empty, lvl.full, lvl.wm};
        AW'(OFS_WMARK): bus_rdata = {{(DW-CW){1'b0}}, wm_q};
        AW'(OFS_EN_TX): bus_rdata = {{(DW-IRQ_W){1'b0}}, en_tx};
        AW'(OFS_EN_RX): bus_rdata = {{(DW-IRQ_W){1'b0}}, en_rx};
        AW'(OFS_ISTAT): bus_rdata = {{(DW-IRQ_W){1'b0}}, istat};
        default:        bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mbox_fifo_chan_chk.sv
module mbox_fifo_chan_chk
  import mbox_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_req,
  input logic             pop_req,
  input logic             flush_req,
  input logic [CW-1:0]    fill,
  input logic [CW-1:0]    wm_q,
  input logic             ovf_stk,
  input logic             udf_stk,
  input logic [DW-1:0]    bus_rdata,
  input logic [IRQ_W-1:0] en_tx,
  input logic             irq_tx
);

  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !flush_req && fill == CW'(DEPTH)) |=> (fill == CW'(DEPTH)));

  a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && fill == '0) |-> (bus_rdata == '0));

  a_r4_empty_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !flush_req && fill == '0) |=> (fill == '0));

  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_stk || udf_stk) && !flush_req) |=> (ovf_stk || udf_stk));

  a_r5_flush_restore: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (fill == '0 && wm_q == CW'(DEPTH) && !ovf_stk && !udf_stk));

  a_r9_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tx == '0) |-> !irq_tx);

endmodule

bind mbox_fifo_chan mbox_fifo_chan_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .flush_req (flush_req),
  .fill      (fill),
  .wm_q      (wm_q),
  .ovf_stk   (ovf_stk),
  .udf_stk   (udf_stk),
  .bus_rdata (bus_rdata),
  .en_tx     (en_tx),
  .irq_tx    (irq_tx)
);

// File: tb/mbox_fifo_chan_bench.sv
module mbox_fifo_chan_bench;

  localparam int D  = 8;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [7:0] A_PUSH = 8'hAC, A_POP = 8'hB0, A_STAT = 8'hB4, A_WM = 8'hB8;
  localparam logic [7:0] A_ETX = 8'hBC, A_ERX = 8'hC0, A_CLR = 8'hC4, A_IST = 8'hC8, A_RST = 8'hCC;

  logic          clk, rst_n, bus_req, bus_we, irq_tx, irq_rx;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model of the channel
  logic [31:0] mq[$];
  int          m_wm;
  bit          m_ovf, m_udf, pl_wm, pl_full, pl_empty;
  logic [8:0]  m_istat, m_etx, m_erx;

  mbox_fifo_chan #(.DEPTH(D), .DW(DW), .AW(AW)) u_mbox_fifo_chan (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit m_wm_lvl();
    return mq.size() >= m_wm;
  endfunction

  function automatic void m_levels();
    bit cw = m_wm_lvl();
    bit cf = (mq.size() == D);
    bit ce = (mq.size() == 0);
    if (cf && !pl_full)  m_istat[2] = 1'b1;
    if (ce && !pl_empty) m_istat[3] = 1'b1;
    if (!ce && pl_empty) m_istat[8] = 1'b1;
    if (cw && !pl_wm)    m_istat[4] = 1'b1;
    if (!cw && pl_wm)    m_istat[5] = 1'b1;
    pl_wm = cw; pl_full = cf; pl_empty = ce;
  endfunction

  function automatic logic [31:0] m_stat();
    return {27'd0, m_ovf, m_udf, mq.size() == 0, mq.size() == D, m_wm_lvl()};
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_push(input logic [31:0] d);
    bus_wr(A_PUSH, d);
    if (mq.size() == D) begin m_ovf = 1; m_istat[6] = 1'b1; end
    else mq.push_back(d);
    m_levels();
  endtask

  task automatic do_pop(input string tag);
    logic [31:0] got, exp;
    bus_rd(A_POP, got);
    if (mq.size() == 0) begin exp = 0; m_udf = 1; m_istat[7] = 1'b1; end
    else exp = mq.pop_front();
    m_levels();
    check(tag, got, exp);
  endtask

  task automatic do_wm(input logic [31:0] d);
    bus_wr(A_WM, d);
    m_wm = int'(d[3:0]);
    m_levels();
  endtask

  task automatic do_clr(input logic [31:0] d);
    bus_wr(A_CLR, d);
    m_istat = m_istat & ~d[8:0];
  endtask

  task automatic do_rst(input logic [31:0] d);
    bus_wr(A_RST, d);
    if (d[0]) begin mq.delete(); m_wm = D; m_ovf = 0; m_udf = 0; end
    m_levels();
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    bus_rd(A_STAT, v); check({tag, " status"}, v, m_stat());
    bus_rd(A_IST, v);  check({tag, " istat"}, v, {23'd0, m_istat});
    check({tag, " irq_tx"}, {31'd0, irq_tx}, {31'd0, |(m_istat & m_etx)});
    check({tag, " irq_rx"}, {31'd0, irq_rx}, {31'd0, |(m_istat & m_erx)});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_wm = D; m_ovf = 0; m_udf = 0; pl_wm = 0; pl_full = 0; pl_empty = 1;
    m_istat = '0; m_etx = '0; m_erx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    check_state("R2 reset");
    bus_rd(A_WM, v);  check("R6 wm default", v, D);
    bus_rd(A_IST, v); check("R8 istat reset", v, 0);
    bus_rd(A_ETX, v); check("R9 tx mask reset", v, 0);

    // Masks keep only bits 2..8
    bus_wr(A_ERX, 32'hFFFF_FFFF); m_erx = 9'h1FC;
    bus_rd(A_ERX, v); check("R9 rx mask readback", v, 32'h1FC);

    // Fill to full, then overflow
    for (int i = 0; i < D; i++) do_push(32'hA000_0000 + i);
    check_state("R7 full");
    do_push(32'hDEAD_BEEF);
    check_state("R3 overflow");
    check("R9 tx quiet", {31'd0, irq_tx}, 0);

    // Drain in order, then underflow
    for (int i = 0; i < D; i++) do_pop("R1 order");
    do_pop("R4 underflow data");
    check_state("R4 underflow");

    // Clearing
    do_clr(32'h0);
    check_state("R8 clear zero");
    do_clr(32'hFFFF_FFFF);
    check_state("R8 clear all");
    check_state("R5 sticky after clear");

    // Store reset with bit0 clear, then set
    do_push(32'h1234_5678);
    do_rst(32'h2);
    check_state("R5 reset bit0 clear");
    do_wm(32'd3);
    do_rst(32'h1);
    check_state("R5 reset");
    bus_rd(A_WM, v); check("R5 wm restored", v, D);

    // Watermark crossings
    do_clr(32'h1FC);
    do_wm(32'd3);
    for (int i = 0; i < 3; i++) do_push(32'h5000 + i);
    check_state("R6 wm up");
    do_pop("R1 order");
    check_state("R6 wm down");

    // Sender mask
    bus_wr(A_ETX, 32'h0000_0020); m_etx = 9'h020;
    check_state("R9 tx mask");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel = int'($urandom_range(0, 99));
      if (sel < 40)      do_push($urandom());
      else if (sel < 75) do_pop("R1 random pop");
      else if (sel < 83) do_wm({28'd0, 4'($urandom_range(0, 15))});
      else if (sel < 90) do_clr($urandom());
      else if (sel < 93) do_rst({31'd0, 1'($urandom_range(0, 1))});
      else if (sel < 96) begin
        bus_wr(A_ETX, $urandom()); m_etx = '0;
        bus_rd(A_ETX, v); m_etx = v[8:0];
        check("R9 random tx mask", {23'd0, m_etx} & 32'hFFFF_FE03, 0);
      end else           check_state("R2 random");
      if (n % 8 == 0) check_state("R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule